// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides when a simple 32-bit processor core leaves its program flow to enter the interrupt handler. It watches a vector of level-sensitive external request lines and records each asserted line in a sticky pending register. A mask register selects which pending requests may interrupt, and a small enable register holds a global enable bit and a saved copy of it. Software reaches all of these through a single-port register interface. That interface also holds the exception base address from which handler addresses are built.

The core itself is represented by its current program counter and a strobe that marks each retired instruction. The decision is made only on a retire strobe, so an interrupt always lands on an instruction boundary. The pending, mask and enable registers are examined in that cycle. When the decision is positive, the block emits a one-cycle entry command on the next clock. The command carries the PC to preserve, the index of the general register that receives it, and the handler address. In the same edge the enable register moves its enable bit into the saved-enable bit.

Top module: `irq_entry_ctrl`

## Requirements
- R1: When request line n is high at a clock edge, bit n of the pending register is 1 after that edge.
- R2: A pending bit stays 1 after its line drops. It is cleared only by a register write to select code 0 (pending) in which the matching data bit is 1. Data bits that are 0 leave the pending bit as it is.
- R3: If a pending-clear write and a high line hit the same bit in the same cycle, the bit ends up 1.
- R4: take_irq is high for exactly one cycle. It rises in the cycle after an edge at which retire was 1, enable bit 0 was 1 and (mask AND pending) was nonzero. It is 0 after every other edge.
- R5: While take_irq is high, save_pc equals the cur_pc value present in the retire cycle. save_reg_idx is always 30.
- R6: While take_irq is high, vector_pc equals the exception base that was in place in the retire cycle, plus 6 times 32 (0xC0).
- R7: The edge that raises take_irq leaves the enable register at 2'b10 (bit 0 clear, bit 1 set). This holds even when a write to select code 2 occurs in the same cycle.
- R8: Select codes are 0 pending, 1 mask, 2 enable and 3 base. Enable takes data bits [1:0] and reads back with its upper bits zero. Base stores data bits [31:8] and reads back with bits [7:0] zero. csr_rdata shows the selected register combinationally.
- R9: A synchronous reset clears pending, mask, enable, base and take_irq to zero.
- R10: A request that is held off by the mask or the enable bit remains pending. It is taken at the first retire after software unblocks it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | Level-sensitive external request lines |
| cur_pc | input | 32 | PC of the core at the current instruction boundary |
| retire | input | 1 | An instruction completes in this cycle |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Selected register contents |
| take_irq | output | 1 | One-cycle interrupt entry command |
| save_pc | output | 32 | Return PC to store during entry |
| save_reg_idx | output | 5 | General register that receives save_pc (30) |
| vector_pc | output | 32 | Handler address to fetch next |

## Verification
Two pairs of actions can land in one cycle. In the first, a line sets a pending bit while software clears that same bit. In the second, interrupt entry rewrites the enable register while software also writes it. Both collisions are driven directly: a line is held high during a write-one-to-clear to its bit, and a retire that satisfies every entry condition coincides with an enable write. Random traffic then makes both collisions happen again many times. Each case is judged by reading the register back through the normal read port and comparing the value with a bench model, in which the set wins over the clear and entry wins over the enable write.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int XLEN      = 32;
    localparam int N_IRQ     = 32;
    localparam int REG_IDX_W = 5;
    localparam int IE_W      = 2;

    typedef enum logic [1:0] {
        CSR_PEND = 2'd0,
        CSR_MASK = 2'd1,
        CSR_ENA  = 2'd2,
        CSR_BASE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic            fire;
        logic [XLEN-1:0] ret_pc;
        logic [XLEN-1:0] vec;
    } entry_cmd_t;

    localparam logic [IE_W-1:0] IE_ON_ENTRY = 2'b10;

    function automatic logic [XLEN-1:0] handler_addr(
        input logic [XLEN-1:0] base,
        input int unsigned     exc_id,
        input int unsigned     slot_shift
    );
        return base + (XLEN'(exc_id) << slot_shift);
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend_q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (lines[i])
                pend_q[i] <= 1'b1;
            else if (clr_vec[i])
                pend_q[i] <= 1'b0;
        end
    end

    // R1: a high line is pending after the edge
    a_r1_line_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(lines)) == $past(lines)));

    // R2, R3: a bit that is set and not cleared stays set
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank
    import irq_entry_pkg::*;
#(
    parameter int XW       = 32,
    parameter int NI       = 32,
    parameter int BASE_LSB = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  csr_sel_e        sel,
    input  logic [XW-1:0]   wdata,
    input  logic            entry,
    output logic [NI-1:0]   mask_q,
    output logic [IE_W-1:0] ie_q,
    output logic [XW-1:0]   base_q
);

    logic wr_mask, wr_ena, wr_base;

    always_comb begin
        wr_mask = we && (sel == CSR_MASK);
        wr_ena  = we && (sel == CSR_ENA);
        wr_base = we && (sel == CSR_BASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ie_q   <= '0;
            base_q <= '0;
        end else begin
            if (wr_mask)
                mask_q <= wdata[NI-1:0];
            if (entry)
                ie_q <= IE_ON_ENTRY;
            else if (wr_ena)
                ie_q <= wdata[IE_W-1:0];
            if (wr_base)
                base_q <= {wdata[XW-1:BASE_LSB], {BASE_LSB{1'b0}}};
        end
    end

    // R7: entry overrides a same-cycle enable write
    a_r7_entry_wins: assert property (@(posedge clk) disable iff (rst)
        entry |=> (ie_q == IE_ON_ENTRY));

    // R8: low base bits never become nonzero
    a_r8_base_align: assert property (@(posedge clk) disable iff (rst)
        wr_base |=> (base_q[BASE_LSB-1:0] == '0));

endmodule

// File: rtl/irq_accept.sv
module irq_accept
    import irq_entry_pkg::*;
#(
    parameter int XW         = 32,
    parameter int NI         = 32,
    parameter int EXC_ID     = 6,
    parameter int SLOT_SHIFT = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          retire,
    input  logic [XW-1:0] cur_pc,
    input  logic [NI-1:0] pend,
    input  logic [NI-1:0] mask,
    input  logic          ie_bit,
    input  logic [XW-1:0] base,
    output logic          entry_now,
    output entry_cmd_t    cmd_q
);

    logic armed;

    always_comb begin
        armed     = |(pend & mask);
        entry_now = retire && ie_bit && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q.fire <= entry_now;
            if (entry_now) begin
                cmd_q.ret_pc <= cur_pc;
                cmd_q.vec    <= handler_addr(base, EXC_ID, SLOT_SHIFT);
            end
        end
    end

    // R4: command only follows a retire
    a_r4_after_retire: assert property (@(posedge clk) disable iff (rst)
        cmd_q.fire |-> $past(retire));

    // R4: one-cycle pulse, since entry clears the enable bit
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_q.fire |=> !cmd_q.fire);

    // R4: no command when enable was off
    a_r4_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ie_bit |=> !cmd_q.fire);

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int EXC_ID   = 6,
    parameter int SAVE_REG = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_IRQ-1:0]     irq_lines,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic                 retire,
    input  logic                 csr_we,
    input  logic [1:0]           csr_sel,
    input  logic [XLEN-1:0]      csr_wdata,
    output logic [XLEN-1:0]      csr_rdata,
    output logic                 take_irq,
    output logic [XLEN-1:0]      save_pc,
    output logic [REG_IDX_W-1:0] save_reg_idx,
    output logic [XLEN-1:0]      vector_pc
);

    localparam int BASE_LSB   = 8;
    localparam int SLOT_SHIFT = 5;

    csr_sel_e          sel;
    logic [N_IRQ-1:0]  clr_vec;
    logic [N_IRQ-1:0]  pend_q;
    logic [N_IRQ-1:0]  mask_q;
    logic [IE_W-1:0]   ie_q;
    logic [XLEN-1:0]   base_q;
    logic              entry_now;
    entry_cmd_t        cmd_q;

    always_comb begin
        sel     = csr_sel_e'(csr_sel);
        clr_vec = (csr_we && sel == CSR_PEND) ? csr_wdata[N_IRQ-1:0] : '0;
    end

    irq_pend_bank #(.N(N_IRQ)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    irq_csr_bank #(.XW(XLEN), .NI(N_IRQ), .BASE_LSB(BASE_LSB)) u_csr (
        .clk    (clk),
        .rst    (rst),
        .we     (csr_we),
        .sel    (sel),
        .wdata  (csr_wdata),
        .entry  (entry_now),
        .mask_q (mask_q),
        .ie_q   (ie_q),
        .base_q (base_q)
    );

    irq_accept #(.XW(XLEN), .NI(N_IRQ), .EXC_ID(EXC_ID), .SLOT_SHIFT(SLOT_SHIFT)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .retire    (retire),
        .cur_pc    (cur_pc),
        .pend      (pend_q),
        .mask      (mask_q),
        .ie_bit    (ie_q[0]),
        .base      (base_q),
        .entry_now (entry_now),
        .cmd_q     (cmd_q)
    );

    always_comb begin
        csr_rdata = '0;
        unique case (sel)
            CSR_PEND: csr_rdata[N_IRQ-1:0] = pend_q;
            CSR_MASK: csr_rdata[N_IRQ-1:0] = mask_q;
            CSR_ENA:  csr_rdata[IE_W-1:0]  = ie_q;
            CSR_BASE: csr_rdata            = base_q;
        endcase
    end

    assign take_irq     = cmd_q.fire;
    assign save_pc      = cmd_q.ret_pc;
    assign vector_pc    = cmd_q.vec;
    assign save_reg_idx = REG_IDX_W'(SAVE_REG);

    // R5: fixed save register index
    a_r5_save_idx: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (save_reg_idx == REG_IDX_W'(SAVE_REG)));

    // R7: enable register shows saved-enable while entry is issued
    a_r7_ie_saved: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (ie_q == IE_ON_ENTRY));

endmodule

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_lines;
    logic [31:0] cur_pc;
    logic        retire;
    logic        csr_we;
    logic [1:0]  csr_sel;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        take_irq;
    logic [31:0] save_pc;
    logic [4:0]  save_reg_idx;
    logic [31:0] vector_pc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_pend, m_mask, m_base;
    logic [1:0]  m_ie;

    always #5 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .cur_pc(cur_pc),
        .retire(retire), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .take_irq(take_irq),
        .save_pc(save_pc), .save_reg_idx(save_reg_idx), .vector_pc(vector_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_vec(input logic [31:0] base);
        return base + 32'd6 * 32'd32;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] s);
        case (s)
            2'd0:    return m_pend;
            2'd1:    return m_mask;
            2'd2:    return {30'd0, m_ie};
            default: return m_base;
        endcase
    endfunction

    // one cycle: drive inputs, predict, cross the edge, compare
    task automatic cyc(input logic [31:0] lines, input bit ret, input logic [31:0] pc,
                       input bit we, input logic [1:0] s, input logic [31:0] wd);
        bit          fire;
        logic [31:0] e_pc, e_vec, clr;
        irq_lines = lines; retire = ret; cur_pc = pc;
        csr_we = we; csr_sel = s; csr_wdata = wd;
        fire  = ret && m_ie[0] && ((m_mask & m_pend) != 0);
        e_pc  = pc;
        e_vec = exp_vec(m_base);
        clr   = (we && s == 2'd0) ? wd : 32'd0;
        @(posedge clk);
        m_pend = (m_pend & ~clr) | lines;
        if (we && s == 2'd1) m_mask = wd;
        if (fire) m_ie = 2'b10;
        else if (we && s == 2'd2) m_ie = wd[1:0];
        if (we && s == 2'd3) m_base = {wd[31:8], 8'h00};
        @(negedge clk);
        csr_we = 1'b0; retire = 1'b0;
        chk(take_irq == fire, "R4 take_irq", {31'd0, take_irq}, {31'd0, fire});
        if (fire) begin
            chk(save_pc == e_pc, "R5 save_pc", save_pc, e_pc);
            chk(save_reg_idx == 5'd30, "R5 save_reg_idx", {27'd0, save_reg_idx}, 32'd30);
            chk(vector_pc == e_vec, "R6 vector_pc", vector_pc, e_vec);
        end
        #1;
        chk(csr_rdata == model_read(s), "R8 csr_rdata", csr_rdata, model_read(s));
    endtask

    task automatic rd(input logic [1:0] s, input string req, input logic [31:0] exp);
        csr_sel = s; #1;
        chk(csr_rdata == exp, req, csr_rdata, exp);
    endtask

    initial begin
        logic [31:0] lines;
        irq_lines = 0; cur_pc = 0; retire = 0; csr_we = 0; csr_sel = 0; csr_wdata = 0;
        m_pend = 0; m_mask = 0; m_ie = 0; m_base = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(take_irq == 1'b0, "R9 take_irq after reset", {31'd0, take_irq}, 32'd0);
        rd(2'd0, "R9 pending reset", 32'd0);
        rd(2'd1, "R9 mask reset", 32'd0);
        rd(2'd2, "R9 enable reset", 32'd0);
        rd(2'd3, "R9 base reset", 32'd0);

        // R1, R2: pulse line 5 then drop it
        cyc(32'h20, 0, 0, 0, 2'd0, 0);
        cyc(32'h0, 0, 0, 0, 2'd0, 0);
        rd(2'd0, "R1 R2 pending held after line drop", 32'h20);
        // R2: clear writes of 0 leave bits untouched
        cyc(32'h0, 0, 0, 1, 2'd0, 32'h0000_0001);
        rd(2'd0, "R2 zero bit leaves pending", 32'h20);
        // R3: set wins over same-cycle clear
        cyc(32'h20, 0, 0, 1, 2'd0, 32'h20);
        rd(2'd0, "R3 set wins over clear", 32'h20);
        cyc(32'h0, 0, 0, 1, 2'd0, 32'h20);
        rd(2'd0, "R2 W1C clears pending", 32'h0);

        // R8: base alignment and enable width
        cyc(32'h0, 0, 0, 1, 2'd3, 32'h1234_56FF);
        rd(2'd3, "R8 base low bits zero", 32'h1234_5600);
        cyc(32'h0, 0, 0, 1, 2'd2, 32'hFFFF_FFFD);
        rd(2'd2, "R8 enable upper bits zero", 32'h1);

        // R10: blocked by mask, then unblocked
        cyc(32'h0000_0100, 0, 0, 0, 2'd0, 0);
        cyc(32'h0, 1, 32'h400, 0, 2'd0, 0);
        chk(take_irq == 1'b0, "R10 masked request not taken", {31'd0, take_irq}, 32'd0);
        cyc(32'h0, 0, 0, 1, 2'd1, 32'h0000_0100);
        cyc(32'h0, 1, 32'h0000_0ABC, 0, 2'd0, 0);
        chk(take_irq == 1'b1, "R10 taken after unmask", {31'd0, take_irq}, 32'd1);
        chk(vector_pc == 32'h1234_56C0, "R6 vector value", vector_pc, 32'h1234_56C0);
        chk(save_pc == 32'h0000_0ABC, "R5 saved pc", save_pc, 32'h0000_0ABC);
        rd(2'd2, "R7 enable after entry", 32'h2);
        cyc(32'h0, 1, 32'h4, 0, 2'd0, 0);
        chk(take_irq == 1'b0, "R4 no repeat while disabled", {31'd0, take_irq}, 32'd0);

        // R7: entry collides with enable write
        cyc(32'h0, 0, 0, 1, 2'd2, 32'h1);
        cyc(32'h0, 1, 32'h88, 1, 2'd2, 32'h1);
        rd(2'd2, "R7 entry wins over enable write", 32'h2);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic [1:0]  s;
            lines = ($urandom % 8 == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
            s  = 2'($urandom);
            wd = $urandom;
            if (s == 2'd2) wd = ($urandom % 4 != 0) ? 32'h1 : wd;
            if (s == 2'd0 && $urandom % 2 == 0) wd = lines;
            cyc(lines, ($urandom % 2) == 0, $urandom, ($urandom % 5) == 0, s, wd);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule